// File: doc/BRIEF.md
# Infrared Gap-Length Command Decoder

This block turns a chip-rate stream from an infrared consumer remote into command words. A demodulator upstream delivers one chip per transfer, 1 for carrier present and 0 for carrier absent. A transmission opens with a long unbroken carrier burst. After that comes a train of packets, repeated for as long as the key is held. Inside a packet, each bit is a single-chip mark. The number of dark chips after that mark carries the bit's value. A packet is closed by a final single-chip mark followed by a long dark gap.

Each packet that decodes cleanly is presented as one output item. The item holds the bits in arrival order, with the first bit in the least significant position, together with the number of bits. A flag tells whether the packet matches the one reported just before it in the same transmission. Both sides are valid/ready streams. An input chip is consumed on any edge where `in_valid` and `in_ready` are both high. An output item is consumed on any edge where `out_valid` and `out_ready` are both high. While an output item waits, `in_ready` is held low, so no chip is lost under back-pressure. Each packet costs one bubble on the input side.

Top module: `ir_gap_decoder`

## Requirements
- R1: Inside a packet, a single high chip followed by exactly one low chip gives bit 0. A single high chip followed by exactly three low chips gives bit 1. The value of a bit is fixed when the high chip after its low run is accepted.
- R2: A high run of at least WAKE_MIN (8) chips marks the start of a transmission. Until the first such run, no packet is reported. A run of 7 high chips does not count as a start.
- R3: The first bit of a packet appears on out_code[0], the next on out_code[1], and so on. out_len gives the bit count, and the bits of out_code at and above out_len are zero.
- R4: A low run reaching GAP_MAX+1 (6) chips closes the packet. The mark just before that gap carries no bit. out_valid rises on the edge that accepts the sixth low chip. A packet with no bits produces no item.
- R5: A low run of 2, 4 or 5 chips, or a high run of 2 to 7 chips while a transmission is open, is a coding error. The packet is then dropped without an item, and the previous reported packet stays the comparison reference.
- R6: A packet carrying more than MAX_BITS (16) bits is dropped. A packet of exactly MAX_BITS bits is reported.
- R7: out_repeat is 1 exactly when the packet's code and length equal those of the last packet reported since the most recent start burst. A new start burst clears that reference.
- R8: While out_valid is high and out_ready is low, out_code, out_len and out_repeat stay stable. During that time in_ready is low.
- R9: After reset, out_valid is 0, in_ready is 1, and no transmission is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A chip is offered |
| in_ready | output | 1 | The decoder can take a chip |
| in_chip | input | 1 | Chip value, 1 = carrier present |
| out_valid | output | 1 | A decoded packet is offered |
| out_ready | input | 1 | Consumer takes the packet |
| out_code | output | MAX_BITS | Packet bits, first received in bit 0 |
| out_len | output | LEN_W | Number of bits in the packet |
| out_repeat | output | 1 | Packet equals the previous one in this transmission |

## Verification
A packet's item appears on the same edge that accepts the sixth dark chip of its closing gap. In that same edge, in_ready falls, and it stays low until the edge where out_ready takes the item. The driver hands over chips one at a time and waits on in_ready, so every chip lands on a known edge. The monitor samples one time unit after each falling edge and pops one expected item per handshake it sees. An item that comes early, late, or without being expected therefore shows up as a mismatch or as an unexpected item. Where a packet must be dropped, the bench waits a few cycles after the closing gap and then compares the count of items seen with the count expected.

// File: rtl/ir_gap_pkg.sv
`timescale 1ns/1ps
package ir_gap_pkg;

  typedef enum logic [1:0] {
    GAP_ZERO,
    GAP_ONE,
    GAP_BAD
  } gap_kind_e;

  // Meaning of a completed dark run that follows a single-chip mark.
  function automatic gap_kind_e classify_gap(input int unsigned run);
    case (run)
      1:       return GAP_ZERO;
      3:       return GAP_ONE;
      default: return GAP_BAD;
    endcase
  endfunction

endpackage

// File: rtl/ir_gap_runs.sv
`timescale 1ns/1ps
// Run-length tracker: reports each finished run and the moment a dark
// run grows past the gap limit.
module ir_gap_runs #(
  parameter int RUN_W   = 4,
  parameter int RUN_MAX = 8,
  parameter int GAP_MAX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             chip,
  output logic             run_done,
  output logic             done_lvl,
  output logic [RUN_W-1:0] done_len,
  output logic             gap_hit
);
  localparam logic [RUN_W-1:0] SAT_L = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0] GAP_L = RUN_W'(GAP_MAX);

  logic             lvl_q;
  logic [RUN_W-1:0] len_q;

  assign run_done = step && (chip != lvl_q);
  assign done_lvl = lvl_q;
  assign done_len = len_q;
  assign gap_hit  = step && !chip && !lvl_q && (len_q == GAP_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      len_q <= SAT_L;
    end else if (step) begin
      if (chip != lvl_q) begin
        lvl_q <= chip;
        len_q <= RUN_W'(1);
      end else if (len_q != SAT_L) begin
        len_q <= len_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_gap_assembler.sv
`timescale 1ns/1ps
// Packet assembler: turns finished runs into bits, tracks the open
// transmission and drops packets with coding faults.
module ir_gap_assembler
  import ir_gap_pkg::*;
#(
  parameter int RUN_W    = 4,
  parameter int WAKE_MIN = 8,
  parameter int GAP_MAX  = 5,
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_done,
  input  logic                done_lvl,
  input  logic [RUN_W-1:0]    done_len,
  input  logic                gap_hit,
  output logic                wake_seen,
  output logic                pkt_done,
  output logic [MAX_BITS-1:0] pkt_code,
  output logic [LEN_W-1:0]    pkt_len
);
  localparam logic [RUN_W-1:0] WAKE_L = RUN_W'(WAKE_MIN);
  localparam logic [RUN_W-1:0] GAP_L  = RUN_W'(GAP_MAX);
  localparam logic [LEN_W-1:0] FULL_L = LEN_W'(MAX_BITS);

  logic                armed_q, active_q, bad_q;
  logic [LEN_W-1:0]    nbits_q;
  logic [MAX_BITS-1:0] code_q;

  logic      is_marker, is_bad_hi, low_end;
  gap_kind_e kind;

  assign wake_seen = run_done && done_lvl && (done_len >= WAKE_L);
  assign is_marker = run_done && done_lvl && (done_len == RUN_W'(1));
  assign is_bad_hi = run_done && done_lvl && (done_len > RUN_W'(1)) && (done_len < WAKE_L);
  assign low_end   = run_done && !done_lvl && (done_len != '0) && (done_len <= GAP_L);
  assign kind      = classify_gap(32'(done_len));

  assign pkt_done = gap_hit && armed_q && active_q && !bad_q && (nbits_q != '0);
  assign pkt_code = code_q;
  assign pkt_len  = nbits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      bad_q    <= 1'b0;
      nbits_q  <= '0;
      code_q   <= '0;
    end else if (wake_seen) begin
      armed_q  <= 1'b1;
      active_q <= 1'b0;
      bad_q    <= 1'b0;
      nbits_q  <= '0;
      code_q   <= '0;
    end else if (armed_q) begin
      if (gap_hit) begin
        active_q <= 1'b0;
        bad_q    <= 1'b0;
        nbits_q  <= '0;
        code_q   <= '0;
      end else if (is_marker) begin
        active_q <= 1'b1;
      end else if (is_bad_hi) begin
        active_q <= 1'b1;
        bad_q    <= 1'b1;
      end else if (low_end && active_q) begin
        if (kind == GAP_BAD || nbits_q == FULL_L) begin
          bad_q <= 1'b1;
        end else begin
          code_q  <= code_q | (MAX_BITS'(kind == GAP_ONE) << nbits_q);
          nbits_q <= nbits_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ir_gap_outreg.sv
`timescale 1ns/1ps
// Output holding register with repeat detection against the last
// reported packet of the current transmission.
module ir_gap_outreg #(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wake_seen,
  input  logic                pkt_done,
  input  logic [MAX_BITS-1:0] pkt_code,
  input  logic [LEN_W-1:0]    pkt_len,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [MAX_BITS-1:0] out_code,
  output logic [LEN_W-1:0]    out_len,
  output logic                out_repeat
);
  logic                prev_ok_q;
  logic [MAX_BITS-1:0] prev_code_q;
  logic [LEN_W-1:0]    prev_len_q;
  logic                same;

  assign same = prev_ok_q && (prev_code_q == pkt_code) && (prev_len_q == pkt_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_code    <= '0;
      out_len     <= '0;
      out_repeat  <= 1'b0;
      prev_ok_q   <= 1'b0;
      prev_code_q <= '0;
      prev_len_q  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (wake_seen) prev_ok_q <= 1'b0;
      if (pkt_done) begin
        out_valid   <= 1'b1;
        out_code    <= pkt_code;
        out_len     <= pkt_len;
        out_repeat  <= same;
        prev_ok_q   <= 1'b1;
        prev_code_q <= pkt_code;
        prev_len_q  <= pkt_len;
      end
    end
  end
endmodule

// File: rtl/ir_gap_decoder.sv
`timescale 1ns/1ps
module ir_gap_decoder #(
  parameter int WAKE_MIN = 8,
  parameter int GAP_MAX  = 5,
  parameter int MAX_BITS = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic                              in_chip,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [MAX_BITS-1:0]               out_code,
  output logic [$clog2(MAX_BITS+1)-1:0]     out_len,
  output logic                              out_repeat
);
  localparam int LEN_W   = $clog2(MAX_BITS + 1);
  localparam int RUN_MAX = (WAKE_MIN > GAP_MAX + 1) ? WAKE_MIN : GAP_MAX + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic                step;
  logic                run_done, done_lvl, gap_hit;
  logic [RUN_W-1:0]    done_len;
  logic                wake_seen, pkt_done;
  logic [MAX_BITS-1:0] pkt_code;
  logic [LEN_W-1:0]    pkt_len;

  assign in_ready = !out_valid;
  assign step     = in_valid && in_ready;

  ir_gap_runs #(.RUN_W(RUN_W), .RUN_MAX(RUN_MAX), .GAP_MAX(GAP_MAX)) runs_i (
    .clk(clk), .rst_n(rst_n), .step(step), .chip(in_chip),
    .run_done(run_done), .done_lvl(done_lvl), .done_len(done_len), .gap_hit(gap_hit)
  );

  ir_gap_assembler #(
    .RUN_W(RUN_W), .WAKE_MIN(WAKE_MIN), .GAP_MAX(GAP_MAX),
    .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)
  ) asm_i (
    .clk(clk), .rst_n(rst_n), .run_done(run_done), .done_lvl(done_lvl),
    .done_len(done_len), .gap_hit(gap_hit), .wake_seen(wake_seen),
    .pkt_done(pkt_done), .pkt_code(pkt_code), .pkt_len(pkt_len)
  );

  ir_gap_outreg #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) out_i (
    .clk(clk), .rst_n(rst_n), .wake_seen(wake_seen), .pkt_done(pkt_done),
    .pkt_code(pkt_code), .pkt_len(pkt_len), .out_ready(out_ready),
    .out_valid(out_valid), .out_code(out_code), .out_len(out_len),
    .out_repeat(out_repeat)
  );
endmodule

// File: rtl/ir_gap_checker.sv
`timescale 1ns/1ps
module ir_gap_checker #(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_chip,
  input logic                out_valid,
  input logic                out_ready,
  input logic [MAX_BITS-1:0] out_code,
  input logic [LEN_W-1:0]    out_len,
  input logic                out_repeat
);
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_len) && $stable(out_repeat));

  p_stall_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_len_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0) && (out_len <= LEN_W'(MAX_BITS)));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_code >> out_len) == '0));

  p_closed_by_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready && !in_chip));
endmodule

bind ir_gap_decoder ir_gap_checker #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_chip(in_chip), .out_valid(out_valid), .out_ready(out_ready),
  .out_code(out_code), .out_len(out_len), .out_repeat(out_repeat)
);

// File: tb/ir_gap_decoder_tb_top.sv
`timescale 1ns/1ps
module ir_gap_decoder_tb_top;
  localparam int MAX_BITS = 16;
  localparam int LEN_W    = $clog2(MAX_BITS + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_chip = 1'b0;
  logic                out_ready = 1'b1;
  logic                in_ready, out_valid, out_repeat;
  logic [MAX_BITS-1:0] out_code;
  logic [LEN_W-1:0]    out_len;

  int total = 0;
  int bad = 0;
  int seen = 0;
  int pushed = 0;
  bit finished = 0;

  logic [MAX_BITS-1:0] q_code[$];
  int                  q_len[$];
  bit                  q_rep[$];
  string               q_tag[$];

  bit                  m_prev_ok = 0;
  logic [MAX_BITS-1:0] m_prev_code = '0;
  int                  m_prev_len = 0;

  always #2 clk = ~clk;

  ir_gap_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chip(in_chip), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_len(out_len), .out_repeat(out_repeat)
  );

  task automatic chk(input bit ok, input string tag, input string detail);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  task automatic put_chip(input logic b);
    in_valid = 1'b1;
    in_chip  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic put_run(input logic b, input int n);
    for (int i = 0; i < n; i++) put_chip(b);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      put_run(1'b1, 1);
      put_run(1'b0, v[i] ? 3 : 1);
    end
    put_run(1'b1, 1);
    put_run(1'b0, 6);
  endtask

  task automatic wake(input int n);
    put_run(1'b1, n);
    put_run(1'b0, 3);
    if (n >= 8) m_prev_ok = 0;
  endtask

  task automatic expect_pkt(input logic [31:0] v, input int n, input string tag);
    logic [MAX_BITS-1:0] c;
    bit r;
    c = v[MAX_BITS-1:0];
    r = m_prev_ok && (m_prev_code == c) && (m_prev_len == n);
    q_code.push_back(c);
    q_len.push_back(n);
    q_rep.push_back(r);
    q_tag.push_back(tag);
    pushed++;
    m_prev_ok = 1;
    m_prev_code = c;
    m_prev_len = n;
  endtask

  task automatic settle_count(input string tag);
    repeat (3) @(negedge clk);
    chk(seen == pushed, tag, $sformatf("items seen %0d expected %0d", seen, pushed));
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        seen++;
        if (q_code.size() == 0) begin
          chk(1'b0, "R2/R5", $sformatf("unexpected item code=%h len=%0d", out_code, out_len));
        end else begin
          logic [MAX_BITS-1:0] ec;
          int el;
          bit er;
          string t;
          ec = q_code.pop_front();
          el = q_len.pop_front();
          er = q_rep.pop_front();
          t  = q_tag.pop_front();
          chk(out_code == ec, {t, " R3 code"}, $sformatf("got %h expected %h", out_code, ec));
          chk(int'(out_len) == el, {t, " R3 len"}, $sformatf("got %0d expected %0d", out_len, el));
          chk(out_repeat == er, {t, " R7 repeat"}, $sformatf("got %0d expected %0d", out_repeat, er));
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog", "run did not complete, got timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", $sformatf("out_valid got %0d expected 0", out_valid));
    chk(in_ready == 1'b1, "R9", $sformatf("in_ready got %0d expected 1", in_ready));
    rst_n = 1'b1;
    @(negedge clk);

    // R2: no start burst (7 highs is too short) -> nothing reported
    wake(7);
    send_bits(32'h5, 4);
    settle_count("R2 short burst");

    // R1 R3: start burst and a nine-bit packet
    wake(8);
    expect_pkt(32'h125, 9, "R1");
    send_bits(32'h125, 9);
    // R7: repeats of the same packet
    expect_pkt(32'h125, 9, "R7 first repeat");
    send_bits(32'h125, 9);
    expect_pkt(32'h125, 9, "R7 second repeat");
    send_bits(32'h125, 9);
    expect_pkt(32'h0C4 >> 2, 6, "R1 other code");
    send_bits(32'h0C4 >> 2, 6);
    settle_count("R1 R7");

    // R4: packet with no bits gives nothing
    put_run(1'b1, 1);
    put_run(1'b0, 6);
    settle_count("R4 empty packet");

    // R5: dark run of two chips
    put_run(1'b1, 1); put_run(1'b0, 1);
    put_run(1'b1, 1); put_run(1'b0, 2);
    put_run(1'b1, 1); put_run(1'b0, 3);
    put_run(1'b1, 1); put_run(1'b0, 6);
    settle_count("R5 dark run of 2");
    // R5: high run of three chips
    put_run(1'b1, 1); put_run(1'b0, 3);
    put_run(1'b1, 3); put_run(1'b0, 1);
    put_run(1'b1, 1); put_run(1'b0, 6);
    settle_count("R5 long mark");
    // R5: reference kept across dropped packets
    expect_pkt(32'h0C4 >> 2, 6, "R5 ref kept");
    send_bits(32'h0C4 >> 2, 6);

    // R6: 17 bits dropped, 16 bits kept
    send_bits(32'h1_5A5A, 17);
    settle_count("R6 overflow");
    expect_pkt(32'hA5C3, 16, "R6 full");
    send_bits(32'hA5C3, 16);

    // R7: a new start burst clears the reference
    wake(12);
    expect_pkt(32'hA5C3, 16, "R7 after new burst");
    send_bits(32'hA5C3, 16);
    settle_count("R7 new burst");

    // R8: back-pressure
    out_ready = 1'b0;
    expect_pkt(32'h3, 2, "R8");
    send_bits(32'h3, 2);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R8 held", $sformatf("out_valid got %0d expected 1", out_valid));
      chk(in_ready == 1'b0, "R8 stall", $sformatf("in_ready got %0d expected 0", in_ready));
      chk(out_code == MAX_BITS'(3), "R8 stable", $sformatf("code got %h expected 3", out_code));
    end
    out_ready = 1'b1;
    settle_count("R8 release");
    chk(in_ready == 1'b1, "R8 resume", $sformatf("in_ready got %0d expected 1", in_ready));

    chk(q_code.size() == 0, "R4", $sformatf("pending items got %0d expected 0", q_code.size()));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule